// File: doc/BRIEF.md
# Segmented Address Translation Unit

The unit turns a logical address into a physical one. The logical address has two parts: a segment number and an offset within that segment. A small on-chip table holds one base/limit pair per segment. A separate length register says how many of the leading table entries are live for the current context.

Each request goes through two compares and one add. First, the segment number is checked against the length register. Next, the offset is checked against the selected entry's limit. Finally, the entry's base is added to the offset. If either compare fails, the unit raises an addressing-error trap instead of producing an address.

Software changes context by rewriting the length register and the entries it needs. No other state has to be flushed. Every response is registered and appears exactly one cycle after its request.

Top module: `seg_xlate_unit`

## Requirements
- R1: While reset is high, and in the cycle after it is released, rsp_valid and rsp_trap are 0 and rsp_pa is 0. Reset clears the length register to 0, so every segment is illegal until software loads it.
- R2: A request whose segment number is greater than or equal to the length register produces rsp_trap=1, rsp_valid=0 and rsp_pa=0 one cycle later, whatever the table holds.
- R3: A request with a legal segment whose offset is greater than or equal to that entry's limit produces rsp_trap=1, rsp_valid=0 and rsp_pa=0 one cycle later.
- R4: A request that passes both checks produces rsp_valid=1, rsp_trap=0 and rsp_pa equal to base plus offset one cycle later. For example, base 1400 with offset 53 gives 1453.
- R5: rsp_valid and rsp_trap are never 1 together. A cycle with req_valid=0 gives rsp_valid=0, rsp_trap=0 and rsp_pa=0 in the next cycle. Requests may arrive back to back, one per cycle.
- R6: A table write, given by cfg_entry_we with cfg_idx, cfg_base and cfg_limit, takes effect from the next cycle. A request in the same cycle as the write is translated with the entry's old contents.
- R7: A write of cfg_len through cfg_len_we changes which segments are legal from the next cycle, and leaves the table contents unchanged.
- R8: The limit compare is strict. Offset limit-1 passes, offset equal to limit traps, and an entry with limit 0 traps for every offset.
- R9: rsp_pa is one bit wider than base and offset, so a carry out of the add is kept. For example, base 0xFFFF plus offset 1 gives 0x10000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_entry_we | input | 1 | Write one table entry |
| cfg_idx | input | $clog2(SEG_COUNT) | Entry to write |
| cfg_base | input | ADDR_W | New base |
| cfg_limit | input | ADDR_W | New limit (segment length) |
| cfg_len_we | input | 1 | Write the length register |
| cfg_len | input | $clog2(SEG_COUNT+1) | New number of live segments |
| req_valid | input | 1 | Request present |
| req_seg | input | $clog2(SEG_COUNT) | Segment number |
| req_off | input | ADDR_W | Offset within the segment |
| rsp_valid | output | 1 | Translation succeeded |
| rsp_trap | output | 1 | Addressing-error trap |
| rsp_pa | output | ADDR_W+1 | Physical address, 0 unless rsp_valid |

## Verification
A configuration write and a translation can land in the same cycle, and they can touch the same segment. The bench provokes this by driving a table write to an entry and a request to that same entry on one clock edge. It then repeats the same request on the following edge. The first response must carry the old base and the second must carry the new one. The same judgement is applied to a length-register write paired with a request on a segment that the write makes illegal.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  // Outcome of the combinational check stage.
  typedef enum logic [1:0] {
    XL_NONE = 2'd0,
    XL_PASS = 2'd1,
    XL_TRAP = 2'd2
  } xl_kind_e;
endpackage

// File: rtl/seg_table.sv
// Base/limit storage: synchronous write, asynchronous read (distributed RAM).
module seg_table #(
  parameter int SEG_COUNT = 8,
  parameter int ADDR_W    = 16,
  localparam int SEG_W    = $clog2(SEG_COUNT)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SEG_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] wr_limit,
  input  logic [SEG_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_base,
  output logic [ADDR_W-1:0] rd_limit
);
  logic [ADDR_W-1:0] base_mem  [SEG_COUNT];
  logic [ADDR_W-1:0] limit_mem [SEG_COUNT];

  always_ff @(posedge clk) begin
    if (we) begin
      base_mem[wr_idx]  <= wr_base;
      limit_mem[wr_idx] <= wr_limit;
    end
  end

  assign rd_base  = base_mem[rd_idx];
  assign rd_limit = limit_mem[rd_idx];
endmodule

// File: rtl/seg_len_reg.sv
// Count of live segments for the current context.
module seg_len_reg #(
  parameter int SEG_COUNT = 8,
  localparam int LEN_W    = $clog2(SEG_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [LEN_W-1:0] wr_len,
  output logic [LEN_W-1:0] len_q
);
  always_ff @(posedge clk) begin
    if (rst)     len_q <= '0;
    else if (we) len_q <= wr_len;
  end
endmodule

// File: rtl/seg_check.sv
// Range check, limit check and base add; purely combinational.
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_COUNT = 8,
  parameter int ADDR_W    = 16,
  localparam int SEG_W    = $clog2(SEG_COUNT),
  localparam int LEN_W    = $clog2(SEG_COUNT + 1)
) (
  input  logic              valid,
  input  logic [SEG_W-1:0]  seg,
  input  logic [ADDR_W-1:0] off,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output xl_kind_e          kind,
  output logic [ADDR_W:0]   pa
);
  logic seg_ok, off_ok;

  assign seg_ok = LEN_W'(seg) < len;
  assign off_ok = off < limit;

  always_comb begin
    kind = XL_NONE;
    pa   = '0;
    if (valid) begin
      if (seg_ok && off_ok) begin
        kind = XL_PASS;
        pa   = {1'b0, base} + {1'b0, off};
      end else begin
        kind = XL_TRAP;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEG_COUNT = 8,
  parameter int ADDR_W    = 16,
  localparam int SEG_W    = $clog2(SEG_COUNT),
  localparam int LEN_W    = $clog2(SEG_COUNT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_entry_we,
  input  logic [SEG_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_limit,
  input  logic              cfg_len_we,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [ADDR_W-1:0] req_off,
  output logic              rsp_valid,
  output logic              rsp_trap,
  output logic [ADDR_W:0]   rsp_pa
);
  logic [ADDR_W-1:0] rd_base, rd_limit;
  logic [LEN_W-1:0]  len_q;
  xl_kind_e          kind;
  logic [ADDR_W:0]   pa_c;

  seg_table #(.SEG_COUNT(SEG_COUNT), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .we(cfg_entry_we), .wr_idx(cfg_idx),
    .wr_base(cfg_base), .wr_limit(cfg_limit),
    .rd_idx(req_seg), .rd_base(rd_base), .rd_limit(rd_limit)
  );

  seg_len_reg #(.SEG_COUNT(SEG_COUNT)) u_len (
    .clk(clk), .rst(rst), .we(cfg_len_we), .wr_len(cfg_len), .len_q(len_q)
  );

  seg_check #(.SEG_COUNT(SEG_COUNT), .ADDR_W(ADDR_W)) u_check (
    .valid(req_valid), .seg(req_seg), .off(req_off), .len(len_q),
    .base(rd_base), .limit(rd_limit), .kind(kind), .pa(pa_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= (kind == XL_PASS);
      rsp_trap  <= (kind == XL_TRAP);
      rsp_pa    <= pa_c;
    end
  end
endmodule

// File: rtl/seg_xlate_unit_chk.sv
module seg_xlate_unit_chk #(
  parameter int SEG_COUNT = 8,
  parameter int ADDR_W    = 16,
  localparam int SEG_W    = $clog2(SEG_COUNT),
  localparam int LEN_W    = $clog2(SEG_COUNT + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [SEG_W-1:0]  req_seg,
  input logic [ADDR_W-1:0] req_off,
  input logic [LEN_W-1:0]  len_q,
  input logic [ADDR_W-1:0] rd_base,
  input logic [ADDR_W-1:0] rd_limit,
  input logic              rsp_valid,
  input logic              rsp_trap,
  input logic [ADDR_W:0]   rsp_pa
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_trap && rsp_pa == '0));

  assert_seg_range_trap_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && (LEN_W'(req_seg) >= len_q))
      |-> (rsp_trap && !rsp_valid && rsp_pa == '0));

  assert_limit_trap_R3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && (LEN_W'(req_seg) < len_q) && (req_off >= rd_limit))
      |-> (rsp_trap && !rsp_valid && rsp_pa == '0));

  assert_pass_sum_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && (LEN_W'(req_seg) < len_q) && (req_off < rd_limit))
      |-> (rsp_valid && !rsp_trap &&
           rsp_pa == ({1'b0, $past(rd_base)} + {1'b0, $past(req_off)})));

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && rsp_trap));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !req_valid) |-> (!rsp_valid && !rsp_trap && rsp_pa == '0));
endmodule

bind seg_xlate_unit seg_xlate_unit_chk #(.SEG_COUNT(SEG_COUNT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
  .len_q(len_q), .rd_base(rd_base), .rd_limit(rd_limit),
  .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_pa(rsp_pa)
);

// File: tb/seg_xlate_unit_tb.sv
module seg_xlate_unit_tb;
  localparam int SEG_COUNT = 8;
  localparam int ADDR_W    = 16;
  localparam int SEG_W     = $clog2(SEG_COUNT);
  localparam int LEN_W     = $clog2(SEG_COUNT + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_entry_we = 1'b0;
  logic [SEG_W-1:0]  cfg_idx = '0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [ADDR_W-1:0] cfg_limit = '0;
  logic              cfg_len_we = 1'b0;
  logic [LEN_W-1:0]  cfg_len = '0;
  logic              req_valid = 1'b0;
  logic [SEG_W-1:0]  req_seg = '0;
  logic [ADDR_W-1:0] req_off = '0;
  logic              rsp_valid, rsp_trap;
  logic [ADDR_W:0]   rsp_pa;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_xlate_unit #(.SEG_COUNT(SEG_COUNT), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_entry_we(cfg_entry_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_len_we(cfg_len_we),
    .cfg_len(cfg_len), .req_valid(req_valid), .req_seg(req_seg),
    .req_off(req_off), .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_pa(rsp_pa)
  );

  // Compare {valid, trap, pa} against the expected triple.
  task automatic chk(input string tag, input logic ev, input logic et,
                     input logic [ADDR_W:0] epa);
    checks++;
    if (rsp_valid !== ev || rsp_trap !== et || rsp_pa !== epa) begin
      errors++;
      $display("FAIL %s: actual valid=%b trap=%b pa=%h expected valid=%b trap=%b pa=%h",
               tag, rsp_valid, rsp_trap, rsp_pa, ev, et, epa);
    end
  endtask

  // Called at a falling edge: drive one request, check its response at the next one.
  task automatic xlate(input string tag, input int seg, input int off,
                       input logic ev, input logic et, input int epa);
    req_valid = 1'b1;
    req_seg   = SEG_W'(seg);
    req_off   = ADDR_W'(off);
    @(negedge clk);
    chk(tag, ev, et, (ADDR_W+1)'(epa));
  endtask

  task automatic idle;
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic put_entry(input int idx, input int base, input int limit);
    cfg_entry_we = 1'b1;
    cfg_idx = SEG_W'(idx); cfg_base = ADDR_W'(base); cfg_limit = ADDR_W'(limit);
    @(negedge clk);
    cfg_entry_we = 1'b0;
  endtask

  task automatic put_len(input int len);
    cfg_len_we = 1'b1;
    cfg_len = LEN_W'(len);
    @(negedge clk);
    cfg_len_we = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 during reset", 1'b0, 1'b0, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", 1'b0, 1'b0, '0);
    xlate("R1/R2 length zero after reset", 0, 0, 1'b0, 1'b1, 0);
    idle();
  endtask

  task automatic t_basic;
    put_entry(0, 1400, 1000);
    put_entry(1, 'h2000, 'h10);
    put_entry(2, 'h8000, 'h100);
    put_entry(3, 'hFFFF, 2);
    put_len(4);
    xlate("R4 seg0 off53", 0, 53, 1'b1, 1'b0, 1453);
    xlate("R8 offset limit-1", 1, 'hF, 1'b1, 1'b0, 'h200F);
    xlate("R3/R8 offset equals limit", 1, 'h10, 1'b0, 1'b1, 0);
    xlate("R3 offset far past limit", 2, 'hFFFF, 1'b0, 1'b1, 0);
    xlate("R2 seg equals length", 4, 0, 1'b0, 1'b1, 0);
    xlate("R2 top seg", 7, 0, 1'b0, 1'b1, 0);
    xlate("R9 carry out", 3, 1, 1'b1, 1'b0, 'h10000);
    idle();
  endtask

  task automatic t_limit_zero;
    put_entry(5, 'h1234, 0);
    put_len(8);
    xlate("R8 limit zero off0", 5, 0, 1'b0, 1'b1, 0);
    xlate("R8 limit zero off max", 5, 'hFFFF, 1'b0, 1'b1, 0);
    idle();
    put_len(4);
  endtask

  task automatic t_idle;
    idle();
    chk("R5 idle quiet", 1'b0, 1'b0, '0);
  endtask

  task automatic t_same_cycle;
    // Write entry 2 and request it in the same cycle: old contents apply.
    cfg_entry_we = 1'b1; cfg_idx = 2; cfg_base = 'h9000; cfg_limit = 'h100;
    req_valid = 1'b1; req_seg = 2; req_off = 5;
    @(negedge clk);
    cfg_entry_we = 1'b0;
    chk("R6 same-cycle write uses old base", 1'b1, 1'b0, 'h8005);
    xlate("R6 next cycle uses new base", 2, 5, 1'b1, 1'b0, 'h9005);
    // Length shrink in the same cycle as a request on segment 3.
    cfg_len_we = 1'b1; cfg_len = 3;
    req_seg = 3; req_off = 0;
    @(negedge clk);
    cfg_len_we = 1'b0;
    chk("R6 same-cycle length write uses old length", 1'b1, 1'b0, 'hFFFF);
    xlate("R6 next cycle uses new length", 3, 0, 1'b0, 1'b1, 0);
    idle();
  endtask

  task automatic t_context;
    put_len(2);
    xlate("R7 seg2 illegal after shrink", 2, 5, 1'b0, 1'b1, 0);
    xlate("R7 seg1 still legal", 1, 1, 1'b1, 1'b0, 'h2001);
    idle();
    put_len(4);
    xlate("R7 seg2 table kept", 2, 5, 1'b1, 1'b0, 'h9005);
    idle();
  endtask

  task automatic t_back_to_back;
    xlate("R5 b2b pass", 0, 0, 1'b1, 1'b0, 1400);
    xlate("R5 b2b trap", 6, 0, 1'b0, 1'b1, 0);
    xlate("R5 b2b pass again", 0, 999, 1'b1, 1'b0, 2399);
    xlate("R5 b2b limit trap", 0, 1000, 1'b0, 1'b1, 0);
    idle();
    chk("R5 quiet after burst", 1'b0, 1'b0, '0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_limit_zero();
    t_idle();
    t_same_cycle();
    t_context();
    t_back_to_back();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule